// File: doc/BRIEF.md
# Byte-Ordered 16-bit DMA Register Access Port

This block lets an 8-bit processor bus reach six 16-bit DMA registers: a source, a destination and a count register on each of two channels. Each register has a live value and a reload latch. Software writes the low byte and then the high byte. The low byte waits in a per-register buffer. The high-byte write then moves both bytes into the reload latch in a single cycle. Software reads the high byte and then the low byte. Reading the high byte captures the low byte of the live value at that moment, so the two halves of a read always belong to the same 16-bit value.

A per-channel write-control input picks the commit mode. In immediate mode, the high-byte write also loads the live register. In staged mode, the live register keeps its old value until that channel's underflow or forced-reload strobe copies the latch into it. The DMA engine, which lies outside this block, updates live values through a separate update port. It reads them through a flat output bus.

Top module: `dma_reg_port`

## Requirements
- R1: A write to a low-byte address stores the byte in that register's buffer only. It changes neither the live value nor the latch.
- R2: A write to a high-byte address loads the latch with {written byte, buffered low byte}.
- R3: When the channel's write-control input is 0, a high-byte write also loads the live value with the same 16 bits. The new value is visible on `live_o` after the write edge.
- R4: When the channel's write-control input is 1, a high-byte write leaves the live value unchanged. A pulse on that channel's `underflow_i` or `reload_i` copies the latch into the live value of all three registers of the channel.
- R5: A high-byte read returns bits 15:8 of the live value and captures bits 7:0. A later low-byte read of the same register returns the captured byte, even if the live value has changed since.
- R6: Each register has its own write buffer and read snapshot, so interleaved accesses to different registers do not disturb each other.
- R7: A high-byte write with no low-byte write before it uses whatever the buffer holds, and no error is reported.
- R8: Register index r = 3*channel + k, where k is 0 for source, 1 for destination and 2 for count. Its low byte is at address 2r and its high byte at address 2r+1. Addresses 12 to 15 ignore writes and read as 0.
- R9: `rdata_o` is registered. It carries the read byte in the cycle after `rd_i` and holds that value until the next read.
- R10: `upd_we_i[r]` loads `upd_val_i` into live register r on the next edge. If a commit to that register (R3 or R4) happens in the same cycle, the commit takes priority.
- R11: After reset, all live values, latches, buffers, snapshots and `rdata_o` are 0.
- R12: A reload or underflow on one channel leaves the other channel's live values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| wctl_i | input | 2 | Per-channel commit mode (1 = staged) |
| underflow_i | input | 2 | Per-channel count underflow pulse |
| reload_i | input | 2 | Per-channel forced reload pulse |
| upd_we_i | input | 6 | Per-register engine update enable |
| upd_val_i | input | 96 | Engine update values, register r at bits 16r+15:16r |
| live_o | output | 96 | Live values, register r at bits 16r+15:16r |

## Verification
Every write, reload, underflow and engine update takes effect on the rising edge of the cycle in which its strobe is high. The bench therefore compares `live_o` with its model at the falling edge that follows. A read result appears on `rdata_o` one edge after `rd_i`. The read driver queues the expected byte, and a monitor pops the queue at the falling edge after the strobe and compares. Hold checks sample `rdata_o` several idle cycles later.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode #(
  parameter int NUM_REG = 6,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [NUM_REG-1:0] wr_lo_o,
  output logic [NUM_REG-1:0] wr_hi_o,
  output logic [NUM_REG-1:0] rd_lo_o,
  output logic [NUM_REG-1:0] rd_hi_o,
  output logic               hit_o
);
  logic [NUM_REG-1:0] sel_lo, sel_hi;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 * r);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(2 * r + 1);
    assign sel_lo[r]  = (addr_i == LO_A);
    assign sel_hi[r]  = (addr_i == HI_A);
    assign wr_lo_o[r] = wr_i & sel_lo[r];
    assign wr_hi_o[r] = wr_i & sel_hi[r];
    assign rd_lo_o[r] = rd_i & sel_lo[r];
    assign rd_hi_o[r] = rd_i & sel_hi[r];
  end

  assign hit_o = |{sel_lo, sel_hi};
endmodule

// File: rtl/dma_port_slice.sv
module dma_port_slice
  import dma_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_lo_i,
  input  logic  wr_hi_i,
  input  logic  rd_hi_i,
  input  logic  wctl_i,
  input  logic  reload_i,
  input  logic  upd_we_i,
  input  byte_t wdata_i,
  input  word_t upd_val_i,
  output word_t live_o,
  output byte_t snap_o
);
  byte_t wbuf_q, snap_q;
  word_t latch_q, latch_d, live_q;
  logic  commit;

  assign latch_d = wr_hi_i ? {wdata_i, wbuf_q} : latch_q;
  // a commit in the same cycle as an engine update wins
  assign commit  = reload_i | (wr_hi_i & ~wctl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q  <= '0;
      latch_q <= '0;
      live_q  <= '0;
      snap_q  <= '0;
    end else begin
      if (wr_lo_i) wbuf_q <= wdata_i;
      latch_q <= latch_d;
      if (commit)        live_q <= latch_d;
      else if (upd_we_i) live_q <= upd_val_i;
      if (rd_hi_i) snap_q <= live_q[BYTE_W-1:0];
    end
  end

  assign live_o = live_q;
  assign snap_o = snap_q;

  assert_lo_only_buffers_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i && !reload_i && !upd_we_i) |=> $stable(live_q) && $stable(latch_q));
  assert_immediate_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wctl_i) |=> live_q == latch_q);
  assert_staged_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && wctl_i && !reload_i && !upd_we_i) |=> $stable(live_q));
  assert_reload_copies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> live_q == latch_q);
  assert_snapshot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> snap_q == $past(live_q[BYTE_W-1:0]));
endmodule

// File: rtl/dma_port_rdmux.sv
module dma_port_rdmux
  import dma_port_pkg::*;
#(
  parameter int NUM_REG = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  logic                      hit_i,
  input  logic [NUM_REG-1:0]        rd_lo_i,
  input  logic [NUM_REG-1:0]        rd_hi_i,
  input  logic [NUM_REG*WORD_W-1:0] live_i,
  input  logic [NUM_REG*BYTE_W-1:0] snap_i,
  output byte_t                     rdata_o
);
  byte_t rd_nxt, rdata_q;

  always_comb begin
    rd_nxt = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (rd_hi_i[r]) rd_nxt |= live_i[r*WORD_W+BYTE_W +: BYTE_W];
      if (rd_lo_i[r]) rd_nxt |= snap_i[r*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit_i) |=> rdata_q == '0);
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_port_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int REGS_PER_CH = 3,
  parameter int ADDR_W      = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [7:0]                            wdata_i,
  input  logic                                  wr_i,
  input  logic                                  rd_i,
  output logic [7:0]                            rdata_o,
  input  logic [NUM_CH-1:0]                     wctl_i,
  input  logic [NUM_CH-1:0]                     underflow_i,
  input  logic [NUM_CH-1:0]                     reload_i,
  input  logic [NUM_CH*REGS_PER_CH-1:0]         upd_we_i,
  input  logic [NUM_CH*REGS_PER_CH*16-1:0]      upd_val_i,
  output logic [NUM_CH*REGS_PER_CH*16-1:0]      live_o
);
  localparam int NUM_REG = NUM_CH * REGS_PER_CH;

  logic [NUM_REG-1:0]        wr_lo, wr_hi, rd_lo, rd_hi;
  logic                      hit;
  logic [NUM_REG*BYTE_W-1:0] snap_all;

  dma_port_decode #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .wr_lo_o(wr_lo),
    .wr_hi_o(wr_hi),
    .rd_lo_o(rd_lo),
    .rd_hi_o(rd_hi),
    .hit_o  (hit)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam int CH = r / REGS_PER_CH;
    dma_port_slice u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_lo_i  (wr_lo[r]),
      .wr_hi_i  (wr_hi[r]),
      .rd_hi_i  (rd_hi[r]),
      .wctl_i   (wctl_i[CH]),
      .reload_i (underflow_i[CH] | reload_i[CH]),
      .upd_we_i (upd_we_i[r]),
      .wdata_i  (wdata_i),
      .upd_val_i(upd_val_i[r*WORD_W +: WORD_W]),
      .live_o   (live_o[r*WORD_W +: WORD_W]),
      .snap_o   (snap_all[r*BYTE_W +: BYTE_W])
    );
  end

  dma_port_rdmux #(.NUM_REG(NUM_REG)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .hit_i  (hit),
    .rd_lo_i(rd_lo),
    .rd_hi_i(rd_hi),
    .live_i (live_o),
    .snap_i (snap_all),
    .rdata_o(rdata_o)
  );

  assert_decode_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo, wr_hi, rd_lo, rd_hi}) || (wr_i && rd_i));
  assert_other_channel_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((underflow_i[0] | reload_i[0]) && !(underflow_i[1] | reload_i[1]) && !wr_i
     && upd_we_i == '0) |=> $stable(live_o[NUM_REG*WORD_W-1:REGS_PER_CH*WORD_W]));
endmodule

// File: tb/tb_dma_reg_port.sv
`timescale 1ns/1ps
module tb_dma_reg_port;
  logic        clk = 0, rst_ni = 0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 0, rd_i = 0;
  logic [7:0]  rdata_o;
  logic [1:0]  wctl_i = '0, underflow_i = '0, reload_i = '0;
  logic [5:0]  upd_we_i = '0;
  logic [95:0] upd_val_i = '0;
  logic [95:0] live_o;

  always #2 clk = ~clk;

  dma_reg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .wctl_i(wctl_i),
    .underflow_i(underflow_i), .reload_i(reload_i), .upd_we_i(upd_we_i),
    .upd_val_i(upd_val_i), .live_o(live_o)
  );

  int errors = 0, checks = 0;
  logic [15:0] m_live [6];
  logic [15:0] m_latch[6];
  logic [7:0]  m_wbuf [6];
  logic [7:0]  m_snap [6];
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  last_rd = '0;
  logic        rd_seen = 0;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_live(int r, string tag);
    checks++;
    if (live_o[r*16 +: 16] !== m_live[r]) begin
      errors++;
      $display("FAIL %s: reg%0d actual=%h expected=%h", tag, r, live_o[r*16 +: 16], m_live[r]);
    end
  endtask

  task automatic chk_all(string tag);
    for (int r = 0; r < 6; r++) chk_live(r, tag);
  endtask

  task automatic model_wr(logic [3:0] a, logic [7:0] d);
    int r;
    if (a >= 12) return;
    r = int'(a) / 2;
    if (!a[0]) m_wbuf[r] = d;
    else begin
      m_latch[r] = {d, m_wbuf[r]};
      if (!wctl_i[r/3]) m_live[r] = m_latch[r];
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1;
    model_wr(a, d);
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    int r;
    logic [7:0] e;
    @(negedge clk);
    addr_i = a; rd_i = 1;
    r = int'(a) / 2;
    if (a >= 12) e = 8'h00;
    else if (a[0]) begin e = m_live[r][15:8]; m_snap[r] = m_live[r][7:0]; end
    else e = m_snap[r];
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 0;
  endtask

  task automatic pulse_reload(int ch, bit uf);
    @(negedge clk);
    if (uf) underflow_i[ch] = 1; else reload_i[ch] = 1;
    for (int r = ch*3; r < ch*3+3; r++) m_live[r] = m_latch[r];
    @(negedge clk);
    underflow_i = '0; reload_i = '0;
  endtask

  task automatic engine_upd(int r, logic [15:0] v);
    @(negedge clk);
    upd_we_i[r] = 1; upd_val_i[r*16 +: 16] = v;
    m_live[r] = v;
    @(negedge clk);
    upd_we_i = '0;
  endtask

  task automatic wr_with_upd(logic [3:0] a, logic [7:0] d, logic [15:0] v);
    int r;
    r = int'(a) / 2;
    @(negedge clk);
    upd_we_i[r] = 1; upd_val_i[r*16 +: 16] = v;
    addr_i = a; wdata_i = d; wr_i = 1;
    m_live[r] = v;
    model_wr(a, d);
    @(negedge clk);
    upd_we_i = '0; wr_i = 0;
  endtask

  // monitor: result is due one edge after the read strobe
  always @(posedge clk) rd_seen <= rd_i;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected read result actual=%h expected=none", rdata_o);
      end else begin
        last_rd = exp_q.pop_front();
        check8(tag_q.pop_front(), rdata_o, last_rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 6; r++) begin
      m_live[r] = '0; m_latch[r] = '0; m_wbuf[r] = '0; m_snap[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk_all("R11 reset live");
    check8("R11 reset rdata", rdata_o, 8'h00);
    rd(4'd1, "R11 reset read hi");
    rd(4'd0, "R11 reset read lo");

    // immediate mode on channel 0
    wr(4'd0, 8'h34);
    chk_live(0, "R1 lo write no commit");
    wr(4'd1, 8'h12);
    chk_live(0, "R3 immediate commit");

    // snapshot across engine update
    rd(4'd1, "R5 read hi");
    engine_upd(0, 16'hABCD);
    chk_live(0, "R10 engine update");
    rd(4'd0, "R5 read lo snapshot");
    rd(4'd1, "R5 read hi new");
    rd(4'd0, "R5 read lo new");
    repeat (3) @(negedge clk);
    check8("R9 rdata hold", rdata_o, last_rd);

    // staged mode on channel 1
    wctl_i = 2'b10;
    wr(4'd6, 8'h78);
    wr(4'd7, 8'h56);
    chk_live(3, "R4 staged no commit");
    pulse_reload(0, 0);
    chk_all("R12 reload ch0 only");
    chk_live(0, "R2 latch into live on reload");
    pulse_reload(1, 1);
    chk_live(3, "R4 underflow commit");

    // interleaved writes and reads
    wctl_i = 2'b00;
    wr(4'd2, 8'h11);
    wr(4'd4, 8'h22);
    wr(4'd3, 8'hA1);
    wr(4'd5, 8'hB2);
    chk_live(1, "R6 interleave reg1");
    chk_live(2, "R6 interleave reg2");
    rd(4'd3, "R6 read hi reg1");
    rd(4'd5, "R6 read hi reg2");
    engine_upd(1, 16'h0F0F);
    engine_upd(2, 16'hF0F0);
    rd(4'd2, "R6 read lo reg1");
    rd(4'd4, "R6 read lo reg2");

    // high write without low
    wr(4'd3, 8'hC3);
    chk_live(1, "R7 hi without lo");

    // unmapped and last register
    wr(4'd12, 8'hFF);
    wr(4'd15, 8'hEE);
    chk_all("R8 unmapped write ignored");
    rd(4'd13, "R8 unmapped read");
    wr(4'd10, 8'h9A);
    wr(4'd11, 8'h5C);
    chk_live(5, "R8 reg5 address");
    rd(4'd11, "R8 read reg5 hi");
    rd(4'd10, "R8 read reg5 lo");

    // commit beats engine update; staged write leaves engine update
    wr(4'd8, 8'h01);
    wr_with_upd(4'd9, 8'h02, 16'h7777);
    chk_live(4, "R10 commit priority");
    wctl_i = 2'b01;
    wr(4'd4, 8'h44);
    wr_with_upd(4'd5, 8'h55, 16'h3333);
    chk_live(2, "R10 staged write with update");
    pulse_reload(0, 1);
    chk_live(2, "R4 ch0 underflow commit");
    chk_live(4, "R12 ch1 untouched");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule